// File: doc/BRIEF.md
# Interleaved Block Refill Controller

This block serves a four-word cache block refill from word-wide memory banks. A refill request carries a block address. The controller sends that address once, waits out the access time and then returns the block one word per response over a one-word bus. A done flag is raised together with the final word. Every latency is a fixed cycle count, so the arrival cycle of each word is known exactly.

Two modes are chosen per request. In interleaved mode one address goes to all banks at once, and the banks access in parallel. Their words are held and then sent out one after another, so the cost is address + access + banks × transfer. In sequential mode the block is fetched as if from a single word-wide memory: address, access and transfer are repeated for each word. A bank write port fills the storage. The two low bits of a word address pick the bank, and the remaining bits pick the row inside that bank.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: After reset, ready_o is 1, and rsp_valid_o and done_o are both 0.
- R2: A request is taken only in a cycle where ready_o is 1. ready_o is 0 from the cycle after acceptance and returns to 1 in the cycle after done_o.
- R3: A request raised while a refill is in progress is ignored. The running refill keeps its words, data and timing, and no further words follow it.
- R4: In interleaved mode (ilv_mode_i = 1), done_o is seen 4 + 24 + 4×4 = 44 clocks after the accepting edge.
- R5: In sequential mode (ilv_mode_i = 0), done_o is seen 4 × (4 + 24 + 4) = 128 clocks after the accepting edge.
- R6: In interleaved mode, word k (k = 0..3) is presented with rsp_valid_o at 28 + 4×(k+1) clocks after the accepting edge.
- R7: In sequential mode, word k is presented at 32×(k+1) clocks after the accepting edge.
- R8: Words arrive in ascending order, with rsp_idx_o = 0, 1, 2, 3. Each word is valid for one cycle. done_o is high only together with the word whose index is 3.
- R9: Word k of block b is the value last written to word address 4b + k. Bits [1:0] of wr_addr_i select the bank, and bits [7:2] select the row.
- R10: The mode is sampled when the request is accepted. Changing ilv_mode_i during a refill has no effect on that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Refill request |
| blk_addr_i | input | 6 | Block address of the request |
| ilv_mode_i | input | 1 | 1 = interleaved, 0 = sequential |
| ready_o | output | 1 | Controller idle, request can be taken |
| wr_en_i | input | 1 | Bank write enable |
| wr_addr_i | input | 8 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | A returned word is on rsp_data_o |
| rsp_idx_o | output | 2 | Index of the word within the block |
| rsp_data_o | output | 32 | Returned word |
| done_o | output | 1 | Last word of the refill |

## Verification
The bench builds the block with its default parameters: four banks, 32-bit words, 64 rows, and 4/24/4 address/access/transfer clocks. These values make the 44- and 128-clock totals and the individual word arrival cycles exact, checkable numbers. With 64 rows, the lowest and highest blocks (0 and 63) can both be reached. Further refills of blocks 1 and 5 cover a stray request raised mid-refill and a mode flip during a refill.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;

  typedef enum logic {
    MODE_SEQ = 1'b0,
    MODE_ILV = 1'b1
  } refill_mode_e;

  // cycles after acceptance at which word k is presented
  function automatic int unsigned word_due(refill_mode_e m, int unsigned k,
                                           int unsigned a, int unsigned acc,
                                           int unsigned x);
    return (m == MODE_ILV) ? a + acc + x * (k + 1) : (a + acc + x) * (k + 1);
  endfunction

  // cycle at which bank k latches its word
  function automatic int unsigned bank_cap(refill_mode_e m, int unsigned k,
                                           int unsigned a, int unsigned acc,
                                           int unsigned x);
    return (m == MODE_ILV) ? a + acc : (a + acc + x) * k + a + acc;
  endfunction

endpackage

// File: rtl/ilv_bank_array.sv
module ilv_bank_array #(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned ROW_W   = 6,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(N_BANKS),
  localparam int unsigned ROWS   = 1 << ROW_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_bank_i,
  input  logic [ROW_W-1:0]                 wr_row_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic [ROW_W-1:0]                 rd_row_i,
  input  logic [N_BANKS-1:0]               cap_i,
  output logic [N_BANKS-1:0][DATA_W-1:0]   hold_o
);

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] mem_q [ROWS];
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == IDX_W'(g))) mem_q[wr_row_i] <= wr_data_i;
    end

    // one word-wide output latch per bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       hold_q <= '0;
      else if (cap_i[g]) hold_q <= mem_q[rd_row_i];
    end

    assign hold_o[g] = hold_q;
  end

endmodule

// File: rtl/ilv_refill_sched.sv
module ilv_refill_sched
  import ilv_refill_pkg::*;
#(
  parameter int unsigned N_BANKS  = 4,
  parameter int unsigned ROW_W    = 6,
  parameter int unsigned ADDR_CYC = 4,
  parameter int unsigned ACC_CYC  = 24,
  parameter int unsigned XFER_CYC = 4,
  localparam int unsigned IDX_W   = $clog2(N_BANKS),
  localparam int unsigned CNT_W   = $clog2(N_BANKS * (ADDR_CYC + ACC_CYC + XFER_CYC) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               mode_i,
  input  logic [ROW_W-1:0]   blk_i,
  output logic               ready_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_BANKS-1:0] cap_o,
  output logic               rsp_valid_o,
  output logic               done_o
);

  logic             busy_q;
  refill_mode_e     mode_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  int unsigned      due_c;
  logic             accept_c;
  logic             last_c;

  assign accept_c = req_i && !busy_q;
  assign due_c    = word_due(mode_q, 32'(idx_q), ADDR_CYC, ACC_CYC, XFER_CYC);
  assign last_c   = (idx_q == IDX_W'(N_BANKS - 1));

  assign rsp_valid_o = busy_q && (32'(cnt_q) == due_c);
  assign done_o      = rsp_valid_o && last_c;
  assign ready_o     = !busy_q;
  assign row_o       = row_q;
  assign idx_o       = idx_q;

  for (genvar g = 0; g < N_BANKS; g++) begin : g_cap
    assign cap_o[g] = busy_q &&
        (32'(cnt_q) == bank_cap(mode_q, 32'(g), ADDR_CYC, ACC_CYC, XFER_CYC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= MODE_SEQ;
      row_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (accept_c) begin
      busy_q <= 1'b1;
      mode_q <= refill_mode_e'(mode_i);
      row_q  <= blk_i;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (rsp_valid_o) idx_q <= idx_q + IDX_W'(1);
      if (done_o)      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ilv_word_sel.sv
module ilv_word_sel #(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(N_BANKS)
) (
  input  logic [N_BANKS-1:0][DATA_W-1:0] hold_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic                           valid_i,
  output logic [DATA_W-1:0]              data_o
);

  assign data_o = valid_i ? hold_i[idx_i] : '0;

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
  parameter int unsigned N_BANKS  = 4,
  parameter int unsigned ROW_W    = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_CYC = 4,
  parameter int unsigned ACC_CYC  = 24,
  parameter int unsigned XFER_CYC = 4,
  localparam int unsigned IDX_W   = $clog2(N_BANKS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [ROW_W-1:0]         blk_addr_i,
  input  logic                     ilv_mode_i,
  output logic                     ready_o,
  input  logic                     wr_en_i,
  input  logic [ROW_W+IDX_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic                     rsp_valid_o,
  output logic [IDX_W-1:0]         rsp_idx_o,
  output logic [DATA_W-1:0]        rsp_data_o,
  output logic                     done_o
);

  logic [ROW_W-1:0]                 row_w;
  logic [N_BANKS-1:0]               cap_w;
  logic [N_BANKS-1:0][DATA_W-1:0]   hold_w;

  ilv_refill_sched #(
    .N_BANKS(N_BANKS), .ROW_W(ROW_W),
    .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
  ) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .mode_i     (ilv_mode_i),
    .blk_i      (blk_addr_i),
    .ready_o    (ready_o),
    .row_o      (row_w),
    .idx_o      (rsp_idx_o),
    .cap_o      (cap_w),
    .rsp_valid_o(rsp_valid_o),
    .done_o     (done_o)
  );

  // low word-address bits pick the bank
  ilv_bank_array #(
    .N_BANKS(N_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) u_banks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_bank_i(wr_addr_i[IDX_W-1:0]),
    .wr_row_i (wr_addr_i[ROW_W+IDX_W-1:IDX_W]),
    .wr_data_i(wr_data_i),
    .rd_row_i (row_w),
    .cap_i    (cap_w),
    .hold_o   (hold_w)
  );

  ilv_word_sel #(
    .N_BANKS(N_BANKS), .DATA_W(DATA_W)
  ) u_sel (
    .hold_i (hold_w),
    .idx_i  (rsp_idx_o),
    .valid_i(rsp_valid_o),
    .data_o (rsp_data_o)
  );

endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk
  import ilv_refill_pkg::*;
#(
  parameter int unsigned N_BANKS  = 4,
  parameter int unsigned ADDR_CYC = 4,
  parameter int unsigned ACC_CYC  = 24,
  parameter int unsigned XFER_CYC = 4,
  localparam int unsigned IDX_W   = $clog2(N_BANKS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ilv_mode_i,
  input logic             ready_o,
  input logic             rsp_valid_o,
  input logic [IDX_W-1:0] rsp_idx_o,
  input logic             done_o
);

  localparam int unsigned ILV_TOTAL = ADDR_CYC + ACC_CYC + N_BANKS * XFER_CYC;
  localparam int unsigned SEQ_TOTAL = N_BANKS * (ADDR_CYC + ACC_CYC + XFER_CYC);

  int unsigned      lat_q;
  refill_mode_e     mode_q;
  logic [IDX_W-1:0] prev_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q      <= 0;
      mode_q     <= MODE_SEQ;
      prev_idx_q <= '0;
    end else begin
      if (req_i && ready_o) begin
        lat_q  <= 1;
        mode_q <= refill_mode_e'(ilv_mode_i);
      end else if (lat_q != 0 && lat_q < 32'hFFFF) begin
        lat_q <= lat_q + 1;
      end
      if (rsp_valid_o) prev_idx_q <= rsp_idx_o;
    end
  end

  p_accept_drops_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  p_ready_after_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);

  p_idle_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !rsp_valid_o);

  p_ilv_total_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_ILV) |-> (lat_q - 1 == ILV_TOTAL));

  p_seq_total_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_SEQ) |-> (lat_q - 1 == SEQ_TOTAL));

  // R6, R7: each word lands on its scheduled cycle
  p_word_due_r6_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (lat_q - 1 ==
      word_due(mode_q, 32'(rsp_idx_o), ADDR_CYC, ACC_CYC, XFER_CYC)));

  p_done_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rsp_valid_o && rsp_idx_o == IDX_W'(N_BANKS - 1)));

  p_idx_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_idx_o != '0) |-> (rsp_idx_o == prev_idx_q + IDX_W'(1)));

  p_single_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

bind ilv_refill_ctrl ilv_refill_chk #(
  .N_BANKS(N_BANKS), .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ilv_mode_i (ilv_mode_i),
  .ready_o    (ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_idx_o  (rsp_idx_o),
  .done_o     (done_o)
);

// File: tb/sim_ilv_refill_ctrl.sv
`timescale 1ns/1ps
module sim_ilv_refill_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  blk = '0;
  logic        mode = 1'b0;
  logic        ready;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_idx;
  logic [31:0] rsp_data;
  logic        done;

  always #2 clk = ~clk;

  ilv_refill_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .blk_addr_i(blk),
    .ilv_mode_i(mode), .ready_o(ready), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rsp_valid_o(rsp_valid), .rsp_idx_o(rsp_idx),
    .rsp_data_o(rsp_data), .done_o(done)
  );

  typedef struct {
    int          idx;
    logic [31:0] data;
    int          cyc;
    bit          last;
    bit          ilv;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model [256];
  int          gcyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          n_extra = 0;
  bit          finished = 0;

  always @(posedge clk) gcyc <= gcyc + 1;

  task automatic check(bit ok, string req_tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every returned word
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          n_extra++;
          check(0, "R3", "unexpected word", longint'(rsp_idx), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(rsp_idx) == e.idx, "R8", "word index", rsp_idx, e.idx);
          check(rsp_data == e.data, "R9", "word data", rsp_data, e.data);
          check(gcyc == e.cyc, e.ilv ? "R6" : "R7", "word cycle", gcyc, e.cyc);
          check(done == e.last, e.ilv ? "R4" : "R5", "done flag", done, e.last);
        end
      end else if (done) begin
        check(0, "R8", "done without word", 1, 0);
      end
    end
  end

  task automatic write_word(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    model[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issues a refill and pushes the expected words
  task automatic refill(int b, bit ilv, bit stray, bit flip);
    int acc;
    @(negedge clk);
    check(ready == 1'b1, "R2", "ready before request", ready, 1);
    req = 1'b1; blk = 6'(b); mode = ilv;
    acc = gcyc + 1;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.idx  = k;
      e.data = model[b * 4 + k];
      e.cyc  = acc + (ilv ? 28 + 4 * (k + 1) : 32 * (k + 1));
      e.last = (k == 3);
      e.ilv  = ilv;
      sb_q.push_back(e);
    end
    @(negedge clk);
    req = 1'b0;
    check(ready == 1'b0, "R2", "ready after accept", ready, 0);
    if (flip) mode = ~ilv;                 // R10
    if (stray) begin                       // R3
      repeat (10) @(negedge clk);
      req = 1'b1; blk = 6'd63; mode = ~ilv;
      @(negedge clk);
      req = 1'b0;
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
    check(ready == 1'b1, "R2", "ready after done", ready, 1);
    mode = ilv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1", "reset ready", ready, 1);
    check(rsp_valid == 1'b0, "R1", "reset valid", rsp_valid, 0);
    check(done == 1'b0, "R1", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && !rsp_valid, "R1", "idle after reset", ready, 1);

    foreach (model[i]) model[i] = '0;
    // R9: distinct pattern per word address
    foreach (model[i]) begin
      int b = i / 4;
      if (b == 0 || b == 1 || b == 5 || b == 63)
        write_word(i, 32'hC0DE_0000 ^ (32'(i) << 8) ^ (32'(i) * 32'h0101_0011));
    end

    refill(5, 1'b1, 1'b0, 1'b0);   // R4 R6
    refill(5, 1'b0, 1'b0, 1'b0);   // R5 R7
    refill(0, 1'b1, 1'b0, 1'b0);
    refill(63, 1'b0, 1'b0, 1'b0);

    write_word(1 * 4 + 2, 32'h1234_5678);   // R9 rewrite one bank
    refill(1, 1'b1, 1'b1, 1'b0);   // R3 stray request
    repeat (60) @(negedge clk);
    check(n_extra == 0, "R3", "words after stray request", n_extra, 0);
    check(ready == 1'b1, "R3", "idle after stray request", ready, 1);

    refill(1, 1'b0, 1'b0, 1'b1);   // R10 seq, mode flipped mid-refill
    refill(5, 1'b1, 1'b0, 1'b1);   // R10 ilv, mode flipped mid-refill

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule